// File: doc/BRIEF.md
# I2C Write-Completion Acknowledge Poller

After a serial EEPROM accepts a write, it spends a variable, device-dependent time programming its cells and ignores the bus until it is done. This master-side controller replaces a fixed worst-case wait with acknowledge polling. It sends a START, then the device select byte with the direction bit at 0, and checks whether the device answers. That select byte is also the first byte of the next transaction. If the device does not acknowledge, it is still busy: the controller stays off the bus for a fixed idle gap and then tries again. When an acknowledge arrives, the controller finishes the opening of the pending operation and hands the bus back to the host.

The host starts a run with a one-cycle `start` pulse and an operation selector. For a write, the controller sends the memory address and the first data byte. For a random read, it sends the address, a repeated START and the select byte with the direction bit at 1. For an operation that does not touch memory, it closes the bus with a STOP. A bounded number of attempts protects against a device that never answers. The controller drives a separate bit-level engine through a command/done handshake.

Top module: `ack_poller`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done`, `eng_req`, `timeout_err` and `nack_err` are 0 and `tries` is 0.
- R2: Each polling attempt is one START command (`eng_cmd`=0) followed by one byte command (`eng_cmd`=1) carrying `{dev_sel,1'b0}`. A command holds `eng_req`, `eng_cmd` and `eng_data` steady until `eng_done`.
- R3: After a select byte that is completed with `eng_nack`=1, `eng_req` stays low for exactly `GAP_CYCLES` cycles and then a new START is requested.
- R4: When the select is acknowledged and `op_sel` was 2 or 3 (no memory access), the next command is STOP (`eng_cmd`=2), and then `done` pulses with both error flags clear.
- R5: When the select is acknowledged and `op_sel` was 0 (write), `ADDR_BYTES` address bytes follow, most significant first, then `wr_byte`, and then `done` pulses. No STOP is issued.
- R6: When the select is acknowledged and `op_sel` was 1 (random read), the address bytes follow, most significant first, then a START, then `{dev_sel,1'b1}`, and then `done` pulses. No STOP is issued.
- R7: If `MAX_TRIES` consecutive select bytes are not acknowledged, a STOP follows and `done` pulses with `timeout_err`=1 and `tries`=`MAX_TRIES`. No further START is issued.
- R8: A not-acknowledged address byte, write data byte or read select byte ends the run with a STOP, and then `done` pulses with `nack_err`=1.
- R9: `done` is high for exactly one cycle per run. `timeout_err`, `nack_err` and `tries` (the number of polling select bytes sent) stay valid until the next accepted `start`.
- R10: `op_sel`, `dev_sel`, `mem_addr` and `wr_byte` are captured on an accepted `start`. A `start` or input change while `busy` is high has no effect on the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling run (accepted only when idle) |
| op_sel | input | 2 | Next operation: 0 write, 1 random read, 2/3 no memory access |
| dev_sel | input | 7 | Device select address |
| mem_addr | input | 8*ADDR_BYTES | Memory address for the next operation |
| wr_byte | input | 8 | First data byte of a next write |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout_err | output | 1 | Attempt limit reached without acknowledge |
| nack_err | output | 1 | Address, data or read select not acknowledged |
| tries | output | $clog2(MAX_TRIES+1) | Polling select bytes sent in the last run |
| eng_req | output | 1 | Command valid to the bit engine |
| eng_cmd | output | 2 | 0 START, 1 send byte and sample ACK, 2 STOP |
| eng_data | output | 8 | Byte for a send-byte command |
| eng_done | input | 1 | Bit engine finished the current command |
| eng_nack | input | 1 | With `eng_done`: the byte was not acknowledged |

## Verification
A wrong state in this controller shows up on the engine command stream, usually at the very next command. A lost attempt count shows up as a run that ends one START too early or too late, or as a wrong `tries` value at `done`. A bad branch after the acknowledge shows up as a STOP where address bytes should come, or as a missing repeated START. The idle gap is measured to the cycle between the not-acknowledged select and the next START request. The error flags are checked both on the `done` cycle and one cycle later.

// File: rtl/ack_poller.sv
module ack_poller #(
  parameter int ADDR_BYTES = 2,
  parameter int MAX_TRIES  = 8,
  parameter int GAP_CYCLES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [1:0]                       op_sel,
  input  logic [6:0]                       dev_sel,
  input  logic [8*ADDR_BYTES-1:0]          mem_addr,
  input  logic [7:0]                       wr_byte,
  output logic                             busy,
  output logic                             done,
  output logic                             timeout_err,
  output logic                             nack_err,
  output logic [$clog2(MAX_TRIES+1)-1:0]   tries,
  output logic                             eng_req,
  output logic [1:0]                       eng_cmd,
  output logic [7:0]                       eng_data,
  input  logic                             eng_done,
  input  logic                             eng_nack
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam int GW     = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam int AW     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);
  localparam logic [GW-1:0]    GAP_LOAD = GW'(GAP_CYCLES - 1);
  localparam logic [AW-1:0]    LAST_AB  = AW'(ADDR_BYTES - 1);

  localparam logic [1:0] CMD_START = 2'd0;
  localparam logic [1:0] CMD_BYTE  = 2'd1;
  localparam logic [1:0] CMD_STOP  = 2'd2;
  localparam logic [1:0] OP_WR     = 2'd0;
  localparam logic [1:0] OP_RD     = 2'd1;

  typedef enum logic [3:0] {
    S_IDLE, S_PSTART, S_PSEL, S_GAP, S_ADDR, S_WDATA, S_RSTART, S_RSEL, S_STOP, S_FIN
  } state_t;

  state_t              state;
  logic [1:0]          op_q;
  logic [6:0]          dev_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [7:0]          data_q;
  logic [AW-1:0]       acnt;
  logic [GW-1:0]       gcnt;
  logic [TRY_W-1:0]    tries_q;
  logic                to_q, nk_q;

  wire mem_op = (op_q == OP_WR) || (op_q == OP_RD);

  assign busy        = (state != S_IDLE);
  assign done        = (state == S_FIN);
  assign tries       = tries_q;
  assign timeout_err = to_q;
  assign nack_err    = nk_q;
  assign eng_req     = (state != S_IDLE) && (state != S_GAP) && (state != S_FIN);

  always_comb begin
    eng_cmd  = CMD_BYTE;
    eng_data = 8'h00;
    case (state)
      S_PSTART, S_RSTART: eng_cmd = CMD_START;
      S_STOP:             eng_cmd = CMD_STOP;
      S_PSEL:             eng_data = {dev_q, 1'b0};
      S_ADDR:             eng_data = addr_q[ADDR_W-1 -: 8];
      S_WDATA:            eng_data = data_q;
      S_RSEL:             eng_data = {dev_q, 1'b1};
      default:            ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= '0;
      dev_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      acnt    <= '0;
      gcnt    <= '0;
      tries_q <= '0;
      to_q    <= 1'b0;
      nk_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (start) begin
            op_q    <= op_sel;
            dev_q   <= dev_sel;
            addr_q  <= mem_addr;
            data_q  <= wr_byte;
            tries_q <= '0;
            to_q    <= 1'b0;
            nk_q    <= 1'b0;
            state   <= S_PSTART;
          end
        S_PSTART:
          if (eng_done) state <= S_PSEL;
        S_PSEL:
          if (eng_done) begin
            tries_q <= tries_q + 1'b1;
            if (!eng_nack) begin
              acnt  <= '0;
              state <= mem_op ? S_ADDR : S_STOP;
            end else if (tries_q == LAST_TRY) begin
              to_q  <= 1'b1;
              state <= S_STOP;
            end else begin
              gcnt  <= GAP_LOAD;
              state <= S_GAP;
            end
          end
        S_GAP:
          if (gcnt == '0) state <= S_PSTART;
          else            gcnt  <= gcnt - 1'b1;
        S_ADDR:
          if (eng_done) begin
            if (eng_nack) begin
              nk_q  <= 1'b1;
              state <= S_STOP;
            end else begin
              addr_q <= addr_q << 8;
              if (acnt == LAST_AB) state <= (op_q == OP_WR) ? S_WDATA : S_RSTART;
              else                 acnt  <= acnt + 1'b1;
            end
          end
        S_WDATA, S_RSEL:
          if (eng_done) begin
            if (eng_nack) begin
              nk_q  <= 1'b1;
              state <= S_STOP;
            end else begin
              state <= S_FIN;
            end
          end
        S_RSTART:
          if (eng_done) state <= S_RSEL;
        S_STOP:
          if (eng_done) state <= S_FIN;
        S_FIN:
          state <= S_IDLE;
        default:
          state <= S_IDLE;
      endcase
    end
  end
endmodule

module ack_poller_chk #(
  parameter int MAX_TRIES  = 8,
  parameter int GAP_CYCLES = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           start,
  input logic                           busy,
  input logic                           done,
  input logic                           timeout_err,
  input logic                           nack_err,
  input logic [$clog2(MAX_TRIES+1)-1:0] tries,
  input logic                           eng_req,
  input logic [1:0]                     eng_cmd,
  input logic [7:0]                     eng_data,
  input logic                           eng_done
);
  logic [15:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                                       quiet_cnt <= '0;
    else if (busy && !eng_req && quiet_cnt != 16'hffff) quiet_cnt <= quiet_cnt + 1'b1;
    else if (!(busy && !eng_req))                     quiet_cnt <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!eng_req && !done));

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_cmd) && $stable(eng_data)));

  // R3
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eng_req) && $past(busy)) |-> (quiet_cnt >= GAP_CYCLES));

  // R7
  timeout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timeout_err) |-> (tries == MAX_TRIES));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout_err && nack_err));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

bind ack_poller ack_poller_chk #(.MAX_TRIES(MAX_TRIES), .GAP_CYCLES(GAP_CYCLES)) u_chk (.*);

// File: tb/ack_poller_test.sv
module ack_poller_test;
  localparam int CLK_PERIOD = 10;
  localparam int AB   = 2;
  localparam int MAXT = 8;
  localparam int GAP  = 4;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [1:0] C_START = 2'd0, C_BYTE = 2'd1, C_STOP = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op_sel = '0;
  logic [6:0] dev_sel = '0;
  logic [8*AB-1:0] mem_addr = '0;
  logic [7:0] wr_byte = '0;
  logic eng_done = 1'b0, eng_nack = 1'b0;
  logic busy, done, timeout_err, nack_err, eng_req;
  logic [TW-1:0] tries;
  logic [1:0] eng_cmd;
  logic [7:0] eng_data;

  ack_poller #(.ADDR_BYTES(AB), .MAX_TRIES(MAXT), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .dev_sel(dev_sel),
    .mem_addr(mem_addr), .wr_byte(wr_byte), .busy(busy), .done(done),
    .timeout_err(timeout_err), .nack_err(nack_err), .tries(tries),
    .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_data(eng_data),
    .eng_done(eng_done), .eng_nack(eng_nack));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // engine model and command log
  logic [1:0] lg_cmd [64];
  logic [7:0] lg_dat [64];
  int lg_rq [64], lg_dn [64];
  int lg_n = 0;
  int busy_left = 0, post_idx = 0, nack_at = -1;
  bit poll_ph = 0, eng_on = 0;

  initial begin : engine
    bit nk;
    wait (eng_on);
    forever begin
      if (!eng_req) @(negedge clk);
      else begin
        if (lg_n < 64) begin
          lg_cmd[lg_n] = eng_cmd; lg_dat[lg_n] = eng_data; lg_rq[lg_n] = cyc;
        end
        repeat ($urandom_range(0, 2)) @(negedge clk);
        nk = 1'b0;
        if (eng_cmd == C_BYTE) begin
          if (poll_ph) begin
            if (busy_left > 0) begin nk = 1'b1; busy_left--; end
            else begin poll_ph = 0; post_idx = 0; end
          end else begin
            nk = (post_idx == nack_at);
            post_idx++;
          end
        end
        if (lg_n < 64) lg_dn[lg_n] = cyc;
        lg_n++;
        eng_done = 1'b1; eng_nack = nk;
        @(negedge clk);
        eng_done = 1'b0; eng_nack = 1'b0;
      end
    end
  end

  // expected stream
  logic [1:0] exp_cmd [64];
  logic [7:0] exp_dat [64];
  int exp_n, exp_tries;
  bit exp_to, exp_nk;

  function automatic void push(input logic [1:0] c, input logic [7:0] d);
    exp_cmd[exp_n] = c; exp_dat[exp_n] = d; exp_n++;
  endfunction

  function automatic void exp_build(input int op, input logic [6:0] dv, input logic [8*AB-1:0] ad,
                                    input logic [7:0] wd, input int bz, input int nat);
    exp_n = 0; exp_to = 0; exp_nk = 0;
    exp_tries = (bz >= MAXT) ? MAXT : bz + 1;
    for (int i = 0; i < exp_tries; i++) begin
      push(C_START, 8'h00); push(C_BYTE, {dv, 1'b0});
    end
    if (bz >= MAXT) begin exp_to = 1; push(C_STOP, 8'h00); return; end
    if (op >= 2) begin push(C_STOP, 8'h00); return; end
    for (int k = 0; k < AB; k++) begin
      push(C_BYTE, ad[8*(AB-1-k) +: 8]);
      if (nat == k) begin exp_nk = 1; push(C_STOP, 8'h00); return; end
    end
    if (op == 0) push(C_BYTE, wd);
    else begin push(C_START, 8'h00); push(C_BYTE, {dv, 1'b1}); end
    if (nat == AB) begin exp_nk = 1; push(C_STOP, 8'h00); end
  endfunction

  task automatic run_op(input int op, input int bz, input int nat, input bit poke, input string rq);
    logic [6:0] dv = 7'($urandom);
    logic [8*AB-1:0] ad = (8*AB)'($urandom);
    logic [7:0] wd = 8'($urandom);
    int n = 0;
    exp_build(op, dv, ad, wd, bz, nat);
    busy_left = bz; poll_ph = 1; nack_at = nat; lg_n = 0;
    @(negedge clk);
    start = 1'b1; op_sel = 2'(op); dev_sel = dv; mem_addr = ad; wr_byte = wd;
    @(negedge clk);
    start = 1'b0; op_sel = 2'($urandom); dev_sel = 7'($urandom);
    mem_addr = (8*AB)'($urandom); wr_byte = 8'($urandom);
    if (poke) begin
      @(negedge clk); start = 1'b1; op_sel = 2'd2;
      @(negedge clk); start = 1'b0;
    end
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, rq, "done seen", done, 1);
    chk(timeout_err == exp_to, "R7", "timeout_err at done", timeout_err, exp_to);
    chk(nack_err == exp_nk, "R8", "nack_err at done", nack_err, exp_nk);
    chk(tries == TW'(exp_tries), "R9", "tries at done", tries, exp_tries);
    @(negedge clk);
    chk(!done, "R9", "done width", done, 0);
    chk(timeout_err == exp_to && nack_err == exp_nk && tries == TW'(exp_tries), "R9",
        "flags held", {timeout_err, nack_err}, {exp_to, exp_nk});
    chk(lg_n == exp_n, rq, "command count", lg_n, exp_n);
    for (int j = 0; j < exp_n && j < lg_n; j++) begin
      chk(lg_cmd[j] == exp_cmd[j], rq, $sformatf("cmd[%0d]", j), lg_cmd[j], exp_cmd[j]);
      if (exp_cmd[j] == C_BYTE)
        chk(lg_dat[j] == exp_dat[j], rq, $sformatf("byte[%0d]", j), lg_dat[j], exp_dat[j]);
    end
    for (int j = 2; j < 2*exp_tries && j < lg_n; j += 2)
      chk(lg_rq[j] - lg_dn[j-1] - 1 == GAP, "R3", "idle gap", lg_rq[j] - lg_dn[j-1] - 1, GAP);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin : main
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !eng_req && !done, "R1", "outputs in reset", {busy, eng_req, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !eng_req && !done && !timeout_err && !nack_err && tries == '0, "R1",
        "outputs after reset", {busy, eng_req, done, timeout_err, nack_err}, 0);
    eng_on = 1;

    run_op(2, 0, -1, 0, "R4");      // immediate ack, no memory access
    run_op(3, 2, -1, 0, "R4");      // busy twice, no memory access
    run_op(0, 3, -1, 0, "R5");      // write after three busy polls
    run_op(1, 2, -1, 0, "R6");      // random read after two busy polls
    run_op(0, 0, -1, 0, "R2");      // write, ready at once
    run_op(0, MAXT, -1, 0, "R7");   // never ready
    run_op(1, MAXT - 1, -1, 0, "R7"); // ready on the last allowed attempt
    run_op(0, 1, 0, 0, "R8");       // first address byte refused
    run_op(0, 0, AB, 0, "R8");      // data byte refused (write protected)
    run_op(1, 1, AB, 0, "R8");      // read select refused
    run_op(0, 2, -1, 1, "R10");     // start pulse while busy ignored
    run_op(1, 0, -1, 1, "R10");

    for (int i = 0; i < 25; i++) begin
      int op = $urandom_range(0, 3);
      int bz = $urandom_range(0, MAXT + 1);
      int nat = ($urandom_range(0, 3) == 0) ? $urandom_range(0, AB) : -1;
      run_op(op, bz, nat, $urandom_range(0, 1), "R2");
    end
    finish_run();
  end
endmodule